// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block is one byte-wide parallel port with two handshake lines. Each data pin can be an input or an output, as a direction register sets. A strobe input (H1) signals that a peripheral has placed data on the pins. A second line (H2) is either a status input whose rising edges are captured, or an output. As an output it holds a fixed level, runs an interlocked input handshake, or runs a pulsed input handshake.

A host reaches the block over a small synchronous register bus with byte-wide read and write strobes and a 3-bit address. A read returns its data on `bus_rdata` one clock after the strobe. In a handshake mode the port latches the pins on the strobe edge. It then holds H2 negated so that the peripheral waits until the host has taken the byte. A host read of the data register releases it.

Top module: `pph_port`

## Requirements
- R1: After reset the control (address 0), direction (address 1) and status (address 4) registers read zero, `pin_out` and `pin_oe` are zero and `h2_oe` is zero.
- R2: A write to address 1 appears on `pin_oe` (bit 1 = output) and a write to address 2 appears on `pin_out`. Outside handshake modes, a read of address 2 returns the written value on output bits and the live `pin_in` level on input bits.
- R3: A read of address 3 returns the live `pin_in` levels. A write to address 3 changes no register and no output.
- R4: With control bit 5 at 0, `h2_oe` is 0 and a rising edge on `h2_in` sets status bit 1. Writing status with bit 1 at 1 clears it; writing bit 1 at 0 leaves it set.
- R5: With control bit 5 at 1, `h2_oe` is 1 and status bit 1 stays 0 whatever `h2_in` does. With control bits 7-6 at 0x, control bits 4-3 = 00 drive `h2_out` low and 01 drive it high.
- R6: With control bits 7-6 at 1x and bit 5 at 1, `h2_out` equals control bit 3, and bit 4 has no effect.
- R7: Interlocked mode is control bits 7-6 = 0x, bit 5 = 1, bits 4-3 = 10. In this mode `h2_out` idles high. A rising `h1_in` with status bit 0 clear latches `pin_in`, sets status bit 0 and drives `h2_out` low from the next cycle.
- R8: In interlocked mode, a read of address 2 while status bit 0 is set returns the latched byte on input bits rather than the live pins. It clears status bit 0, and `h2_out` is high again in the cycle after the read.
- R9: While status bit 0 is set, further `h1_in` rising edges do not overwrite the latched byte.
- R10: Pulsed mode is bits 4-3 = 11 with the rest as in R7. In this mode `h2_out` idles low. A read of address 2 while status bit 0 is set drives `h2_out` high for exactly PULSE_LEN (default 4) cycles, starting in the cycle after the read.
- R11: Status bit 4 reports the live `h1_in` level. Status bit 5 reports the H2 pin level, which is `h2_out` when it is an output and `h2_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid the cycle after `bus_rd` |
| pin_in | input | W | Levels on the data pins |
| pin_out | output | W | Output data for the pins |
| pin_oe | output | W | Per-pin output enable |
| h1_in | input | 1 | Strobe from the peripheral, active high |
| h2_in | input | 1 | H2 level when it is an input |
| h2_out | output | 1 | H2 drive value |
| h2_oe | output | 1 | H2 output enable |

## Verification
Every register-visible result lands one clock after its cause. This covers a write reaching `pin_out` or `pin_oe`, a strobe setting a status flag or negating H2, and a read returning `bus_rdata` and releasing H2. The pulse then stays high for PULSE_LEN further clock edges. Stimulus changes on the falling edge, and every pin check samples on the next falling edge, half a cycle after the register moves. The scoreboard monitor pairs each queued expected read value with the strobe seen at the previous rising edge. The pulse check counts falling edges one by one, so both a short pulse and a long pulse are caught.

// File: rtl/pph_pkg.sv
package pph_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_DIR  = 3'd1,
        REG_DATA = 3'd2,
        REG_ALT  = 3'd3,
        REG_STAT = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        H2F_LOW   = 2'b00,
        H2F_HIGH  = 2'b01,
        H2F_ILOCK = 2'b10,
        H2F_PULSE = 2'b11
    } h2_func_e;

    // control field positions
    localparam int C_SUB_HI = 7;
    localparam int C_H2_DIR = 5;
    localparam int C_FN_HI  = 4;
    localparam int C_FN_LO  = 3;

    // status field positions
    localparam int S_H2_LVL = 5;
    localparam int S_H1_LVL = 4;
    localparam int S_H2S    = 1;
    localparam int S_H1S    = 0;
endpackage

// File: rtl/pph_edge.sv
module pph_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = sig[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pph_pulse.sv
module pph_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/pph_h2_sel.sv
module pph_h2_sel
    import pph_pkg::*;
(
    input  logic       sub_hi,
    input  logic       h2_dir,
    input  logic [1:0] fn,
    input  logic       buf_full,
    input  logic       pulse_on,
    output logic       h2_out,
    output logic       h2_oe,
    output logic       mode_ilock,
    output logic       mode_pulse
);
    h2_func_e fn_e;

    always_comb begin
        fn_e       = h2_func_e'(fn);
        h2_oe      = h2_dir;
        mode_ilock = h2_dir && !sub_hi && (fn_e == H2F_ILOCK);
        mode_pulse = h2_dir && !sub_hi && (fn_e == H2F_PULSE);
        h2_out     = 1'b0;
        if (h2_dir) begin
            if (sub_hi) begin
                h2_out = fn[0];
            end else begin
                case (fn_e)
                    H2F_LOW:   h2_out = 1'b0;
                    H2F_HIGH:  h2_out = 1'b1;
                    H2F_ILOCK: h2_out = !buf_full;
                    H2F_PULSE: h2_out = pulse_on;
                    default:   h2_out = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pph_port.sv
module pph_port
    import pph_pkg::*;
#(
    parameter int W         = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    input  logic              h1_in,
    input  logic              h2_in,
    output logic              h2_out,
    output logic              h2_oe
);
    typedef struct packed {
        logic [W-1:0] ctrl;
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] latch;
        logic [W-1:0] rdata;
        logic         h1s;
        logic         h2s;
    } state_t;

    state_t s_d, s_q;

    logic [1:0] rise;
    logic       mode_ilock, mode_pulse, hs_mode;
    logic       pulse_on, pulse_start;
    logic       rd_data, wr_stat, h2_pin;
    logic [W-1:0] in_view, stat_view;

    // internal views for the bound checker
    logic [W-1:0] ctrl_q;
    logic         h1s_q, h2s_q;
    assign ctrl_q = s_q.ctrl;
    assign h1s_q  = s_q.h1s;
    assign h2s_q  = s_q.h2s;

    pph_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({h2_in, h1_in}),
        .rise  (rise)
    );

    pph_h2_sel u_sel (
        .sub_hi     (s_q.ctrl[C_SUB_HI]),
        .h2_dir     (s_q.ctrl[C_H2_DIR]),
        .fn         (s_q.ctrl[C_FN_HI:C_FN_LO]),
        .buf_full   (s_q.h1s),
        .pulse_on   (pulse_on),
        .h2_out     (h2_out),
        .h2_oe      (h2_oe),
        .mode_ilock (mode_ilock),
        .mode_pulse (mode_pulse)
    );

    pph_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pulse_start),
        .active (pulse_on)
    );

    always_comb begin
        hs_mode     = mode_ilock | mode_pulse;
        rd_data     = bus_rd && (bus_addr == REG_DATA);
        wr_stat     = bus_wr && (bus_addr == REG_STAT);
        pulse_start = mode_pulse && rd_data && s_q.h1s;
        h2_pin      = h2_oe ? h2_out : h2_in;

        in_view = hs_mode ? s_q.latch : pin_in;

        stat_view           = '0;
        stat_view[S_H2_LVL] = h2_pin;
        stat_view[S_H1_LVL] = h1_in;
        stat_view[S_H2S]    = s_q.h2s;
        stat_view[S_H1S]    = s_q.h1s;

        s_d = s_q;

        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL: s_d.ctrl = bus_wdata;
                REG_DIR:  s_d.dir  = bus_wdata;
                REG_DATA: s_d.dout = bus_wdata;
                default:  ;
            endcase
        end

        // strobe capture and buffer release
        if (hs_mode) begin
            if (rise[0] && !s_q.h1s) begin
                s_d.latch = pin_in;
                s_d.h1s   = 1'b1;
            end
            if (rd_data && s_q.h1s) s_d.h1s = 1'b0;
        end else begin
            s_d.h1s = 1'b0;
        end

        // H2 edge status: write-one clear, edge set, held clear as output
        if (wr_stat && bus_wdata[S_H2S]) s_d.h2s = 1'b0;
        if (!s_q.ctrl[C_H2_DIR] && rise[1]) s_d.h2s = 1'b1;
        if (s_d.ctrl[C_H2_DIR]) s_d.h2s = 1'b0;

        if (bus_rd) begin
            case (bus_addr)
                REG_CTRL: s_d.rdata = s_q.ctrl;
                REG_DIR:  s_d.rdata = s_q.dir;
                REG_DATA: s_d.rdata = (s_q.dout & s_q.dir) | (in_view & ~s_q.dir);
                REG_ALT:  s_d.rdata = pin_in;
                REG_STAT: s_d.rdata = stat_view;
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign pin_out   = s_q.dout;
    assign pin_oe    = s_q.dir;
endmodule

// File: rtl/pph_port_chk.sv
module pph_port_chk #(
    parameter int W         = 8,
    parameter int PULSE_LEN = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   bus_addr,
    input logic         bus_wr,
    input logic         bus_rd,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic         h1_in,
    input logic         h2_out,
    input logic         h2_oe,
    input logic         sub_hi,
    input logic         h2_dir,
    input logic [1:0]   fn,
    input logic         h1s,
    input logic         h2s
);
    logic il, pl;
    logic [15:0] hi_run;

    assign il = h2_dir && !sub_hi && (fn == 2'b10);
    assign pl = h2_dir && !sub_hi && (fn == 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n)                hi_run <= '0;
        else if (pl && h2_out)     hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
        else                       hi_run <= '0;
    end

    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (pin_oe == $past(bus_wdata)));

    a_r3_alt_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(h2_oe)));

    a_r5_h2s_clear_as_output: assert property (@(posedge clk) disable iff (!rst_n)
        h2_oe |-> !h2s);

    a_r7_strobe_negates_h2: assert property (@(posedge clk) disable iff (!rst_n)
        (il && $rose(h1_in) && !h1s && !bus_wr) |=> !h2_out);

    a_r8_read_releases_h2: assert property (@(posedge clk) disable iff (!rst_n)
        (il && h1s && bus_rd && bus_addr == 3'd2 && !bus_wr) |=> (!h1s && h2_out));

    a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (pl && h2_out) |-> (hi_run < 16'(PULSE_LEN)));
endmodule

bind pph_port pph_port_chk #(.W(W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .h1_in     (h1_in),
    .h2_out    (h2_out),
    .h2_oe     (h2_oe),
    .sub_hi    (ctrl_q[7]),
    .h2_dir    (ctrl_q[5]),
    .fn        (ctrl_q[4:3]),
    .h1s       (h1s_q),
    .h2s       (h2s_q)
);

// File: tb/tb_pph_port.sv
`timescale 1ns/1ps
module tb_pph_port;
    localparam int W = 8;
    localparam int PL = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe;
    logic         h1_in = 1'b0;
    logic         h2_in = 1'b0;
    logic         h2_out, h2_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [W-1:0] exp_q[$];
    string        req_q[$];

    always #4 clk = ~clk;

    pph_port #(.W(W), .PULSE_LEN(PL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .h1_in(h1_in), .h2_in(h2_in), .h2_out(h2_out), .h2_oe(h2_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares the read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: pushes the expected value, then issues the read
    task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", pin_out, 8'h00);
        check("R1", pin_oe, 8'h00);
        check("R1", {7'd0, h2_oe}, 8'h00);
        rd(3'd0, 8'h00, "R1");
        rd(3'd1, 8'h00, "R1");
        rd(3'd4, 8'h00, "R1");

        // R2 direction and data
        wr(3'd1, 8'hF0);
        check("R2", pin_oe, 8'hF0);
        wr(3'd2, 8'hA5);
        check("R2", pin_out, 8'hA5);
        pin_in = 8'h3C;
        rd(3'd2, 8'hAC, "R2");

        // R3 alternate register
        rd(3'd3, 8'h3C, "R3");
        wr(3'd3, 8'hFF);
        check("R3", pin_out, 8'hA5);
        check("R3", pin_oe, 8'hF0);
        rd(3'd0, 8'h00, "R3");
        rd(3'd2, 8'hAC, "R3");

        // R4 H2 edge capture, write-one clear
        check("R4", {7'd0, h2_oe}, 8'h00);
        @(negedge clk); h2_in = 1'b1;
        rd(3'd4, 8'h22, "R4");
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h22, "R4");
        wr(3'd4, 8'h02);
        rd(3'd4, 8'h20, "R4");
        h2_in = 1'b0;
        rd(3'd4, 8'h00, "R4");

        // R11 H1 level
        h1_in = 1'b1;
        rd(3'd4, 8'h10, "R11");
        h1_in = 1'b0;

        // R5 H2 as static output
        wr(3'd0, 8'h20);
        check("R5", {7'd0, h2_oe}, 8'h01);
        check("R5", {7'd0, h2_out}, 8'h00);
        h2_in = 1'b1;
        @(negedge clk);
        rd(3'd4, 8'h00, "R5");
        h2_in = 1'b0;
        wr(3'd0, 8'h28);
        check("R5", {7'd0, h2_out}, 8'h01);
        rd(3'd4, 8'h20, "R11");

        // R6 submode 1x: only bit 3 matters
        wr(3'd0, 8'hB0);
        check("R6", {7'd0, h2_out}, 8'h00);
        wr(3'd0, 8'hA8);
        check("R6", {7'd0, h2_out}, 8'h01);
        wr(3'd0, 8'hF8);
        check("R6", {7'd0, h2_out}, 8'h01);

        // R7 interlocked handshake
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h30);
        check("R7", {7'd0, h2_out}, 8'h01);
        pin_in = 8'h5A;
        h1_in = 1'b1;
        @(negedge clk);
        check("R7", {7'd0, h2_out}, 8'h00);
        rd(3'd4, 8'h11, "R7");
        // R9 second strobe while full is ignored
        pin_in = 8'h99;
        h1_in = 1'b0;
        @(negedge clk); h1_in = 1'b1;
        @(negedge clk);
        check("R9", {7'd0, h2_out}, 8'h00);
        rd(3'd2, 8'h5A, "R8");
        check("R8", {7'd0, h2_out}, 8'h01);
        rd(3'd4, 8'h30, "R8");
        h1_in = 1'b0;

        // R10 pulsed handshake
        wr(3'd0, 8'h38);
        check("R10", {7'd0, h2_out}, 8'h00);
        pin_in = 8'h77;
        h1_in = 1'b1;
        @(negedge clk);
        h1_in = 1'b0;
        check("R10", {7'd0, h2_out}, 8'h00);
        rd(3'd2, 8'h77, "R10");
        for (int i = 0; i < PL; i++) begin
            check("R10", {7'd0, h2_out}, 8'h01);
            @(negedge clk);
        end
        check("R10", {7'd0, h2_out}, 8'h00);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d expected 0 pending", exp_q.size());
        end
        finish_run();
    end
endmodule